// File: doc/BRIEF.md
# Adaptive Differential Sample Codec

This block compresses and expands 16-bit two's complement audio samples one at a time, using a four-bit adaptive differential code. In compress mode each accepted sample is compared with a prediction, which is the previously reconstructed sample. The signed difference is quantised into one sign bit and three magnitude bits, measured against an adaptive step size. In expand mode each accepted code is turned back into a sample.

Both directions run the same reconstruction path. The prediction is therefore always built from quantised data, and a stream compressed by this block expands to exactly the samples the compressor reconstructed internally. The step size comes from a computed table of 89 levels, addressed by a step index. Each code moves the index, so quiet signals are quantised with fine steps and loud signals with coarse ones. The only state kept between samples is the previous reconstruction and the step index.

A message starts from a cleared state. The state is cleared when `clear_i` is pulsed, and it is also cleared when the direction changes between two accepted items. Each accepted item produces one result on the next clock edge.

Top module: `adpcm_codec`

## Requirements
- R1: While reset is asserted, `out_valid_o` and `in_ready_o` are low. After reset the predicted sample and the step index are both 0.
- R2: In compress mode (`mode_i`=0), code bit 3 is 1 exactly when sample minus prediction is negative. With m the absolute difference and s the step: bit 2 is set when m >= s, and then s is subtracted from m. Bit 1 is then set when the remainder >= s>>1, and then s>>1 is subtracted. Bit 0 is set when what remains >= s>>2.
- R3: The reconstruction adds up the following terms: s>>3, plus s if bit 2 is set, plus s>>1 if bit 1 is set, plus s>>2 if bit 0 is set. This sum is subtracted from the prediction when bit 3 is 1 and added to it otherwise. The result saturates to -32768..32767. A code with bit 3 clear never yields a sample below the prediction, and a code with bit 3 set never yields one above it.
- R4: After each item the step index changes by -1 when the magnitude bits (2..0) are 0 to 3. For magnitude bits 4, 5, 6 and 7 it changes by +2, +4, +6 and +8 respectively. The index is clamped to 0..88.
- R5: The step for index 0 is 7. Each following entry is the larger of (previous+1) and (11*previous+5)/10 in integer arithmetic, limited to 32767. Entry 88 is 32767.
- R6: In expand mode (`mode_i`=1), `code_i` drives the same reconstruction and index update as R3 and R4. A code stream produced in compress mode from a cleared state expands, from a cleared state, to the same samples that compress mode output.
- R7: `in_ready_o` is high on every cycle after reset. An item is accepted when `in_valid_i` is high. Exactly one cycle later `out_valid_o` is high for one cycle. At that point `sample_o` holds the new reconstruction and `code_o` holds the code used: the computed code in compress mode, or `code_i` in expand mode.
- R8: `clear_i` zeroes the prediction and the step index. If an item is accepted in the same cycle, that item is coded from the zeroed state, and the state then advances from it.
- R9: An accepted item whose `mode_i` differs from that of the previously accepted item is coded from a zeroed state. The direction recorded after reset is compress.
- R10: In a cycle with neither `in_valid_i` nor `clear_i`, no result is produced and the state is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous state clear for a new message |
| mode_i | input | 1 | 0 = compress a sample, 1 = expand a code |
| in_valid_i | input | 1 | Input item present |
| in_ready_o | output | 1 | Block can accept an item |
| sample_i | input | 16 | Sample to compress (two's complement) |
| code_i | input | 4 | Code to expand |
| out_valid_o | output | 1 | Result present |
| sample_o | output | 16 | Reconstructed sample |
| code_o | output | 4 | Code used for this item |

## Verification
A state clear and an item acceptance can land in the same cycle. A change of direction also implies a clear. The bench pulses `clear_i` together with a valid item, and it also flips `mode_i` on an item with no explicit clear. In both cases the result is judged against a behavioural model that zeroes its state before coding that item. Separately, a compressed message is expanded again and compared sample for sample with what the compressor reconstructed. Large alternating swings drive the saturation limits and the top of the step index, and a long run of zeros drives the index back down to 0.

// File: rtl/adpcm_pkg.sv
package adpcm_pkg;
  localparam int SAMPLE_W = 16;
  localparam int CODE_W   = 4;
  localparam int MAG_BITS = CODE_W - 1;
  localparam int IDX_MAX  = 88;
  localparam int IDX_W    = $clog2(IDX_MAX + 1);
  localparam int STEP_W   = SAMPLE_W - 1;
  localparam int STEP_MIN = 7;
  localparam int STEP_MAX = (1 << STEP_W) - 1;

  typedef logic [IDX_W-1:0]    idx_t;
  typedef logic [STEP_W-1:0]   step_t;
  typedef logic [SAMPLE_W-1:0] smp_t;
  typedef logic [CODE_W-1:0]   code_t;

  // geometric ~1.1x growth, at least +1 per entry, top entry pinned to max
  function automatic int step_value(int i);
    int s;
    int n;
    s = STEP_MIN;
    for (int k = 1; k <= i && k <= IDX_MAX; k++) begin
      n = (s * 11 + 5) / 10;
      if (n < s + 1) n = s + 1;
      if (n > STEP_MAX) n = STEP_MAX;
      s = n;
    end
    if (i >= IDX_MAX) s = STEP_MAX;
    return s;
  endfunction
endpackage

// File: rtl/adpcm_step_rom.sv
module adpcm_step_rom
  import adpcm_pkg::*;
(
  input  idx_t  idx_i,
  output step_t step_o
);
  localparam int TAB_N = 1 << IDX_W;

  step_t tab [TAB_N];

  for (genvar g = 0; g < TAB_N; g++) begin : g_tab
    localparam int SV = step_value(g);
    assign tab[g] = step_t'(SV);
  end

  assign step_o = tab[idx_i];
endmodule

// File: rtl/adpcm_quant.sv
module adpcm_quant
  import adpcm_pkg::*;
(
  input  smp_t  sample_i,
  input  smp_t  prev_i,
  input  step_t step_i,
  output code_t code_o
);
  localparam int DW = SAMPLE_W + 1;

  logic [DW-1:0]       d_u;
  logic [DW-1:0]       mag;
  logic [DW-1:0]       rem;
  logic [DW-1:0]       thr;
  logic                neg;
  logic [MAG_BITS-1:0] mb;

  always_comb begin
    d_u = {sample_i[SAMPLE_W-1], sample_i} - {prev_i[SAMPLE_W-1], prev_i};
    neg = d_u[DW-1];
    mag = neg ? (~d_u + 1'b1) : d_u;
    rem = mag;
    mb  = '0;
    thr = '0;
    // successive approximation against step, step/2, step/4
    for (int b = MAG_BITS - 1; b >= 0; b--) begin
      thr = DW'(step_i) >> (MAG_BITS - 1 - b);
      if (rem >= thr) begin
        mb[b] = 1'b1;
        rem   = rem - thr;
      end
    end
    code_o = {neg, mb};
  end
endmodule

// File: rtl/adpcm_recon.sv
module adpcm_recon
  import adpcm_pkg::*;
(
  input  code_t code_i,
  input  smp_t  prev_i,
  input  step_t step_i,
  input  idx_t  idx_i,
  output smp_t  sample_o,
  output idx_t  idx_o
);
  localparam int AW = SAMPLE_W + 2;
  localparam logic [AW-1:0] S_MAX = AW'((1 << (SAMPLE_W - 1)) - 1);
  localparam logic [AW-1:0] S_MIN = ~S_MAX;
  localparam int HALF = 1 << (MAG_BITS - 1);

  logic [AW-1:0] vp;
  logic [AW-1:0] prev_x;
  logic [AW-1:0] sum;
  int            adj;
  int            t;

  always_comb begin
    vp = AW'(step_i >> MAG_BITS);
    for (int b = 0; b < MAG_BITS; b++) begin
      if (code_i[b]) vp = vp + AW'(step_i >> (MAG_BITS - 1 - b));
    end
    prev_x = {{2{prev_i[SAMPLE_W-1]}}, prev_i};
    sum    = code_i[CODE_W-1] ? (prev_x - vp) : (prev_x + vp);
    if ($signed(sum) > $signed(S_MAX))      sample_o = smp_t'(S_MAX);
    else if ($signed(sum) < $signed(S_MIN)) sample_o = smp_t'(S_MIN);
    else                                    sample_o = smp_t'(sum);
  end

  always_comb begin
    if (int'(code_i[MAG_BITS-1:0]) < HALF) adj = -1;
    else adj = 2 * (int'(code_i[MAG_BITS-1:0]) - (HALF - 1));
    t = int'(idx_i) + adj;
    if (t < 0) t = 0;
    if (t > IDX_MAX) t = IDX_MAX;
    idx_o = idx_t'(t);
  end

  // R3: result moves away from the prediction only in the coded direction
  always_comb begin
    if (!code_i[CODE_W-1])
      a_r3_dir_up: assert ($signed(sample_o) >= $signed(prev_i));
    else
      a_r3_dir_dn: assert ($signed(sample_o) <= $signed(prev_i));
  end
endmodule

// File: rtl/adpcm_codec.sv
module adpcm_codec
  import adpcm_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                mode_i,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [CODE_W-1:0]   code_i,
  output logic                out_valid_o,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic [CODE_W-1:0]   code_o
);
  smp_t  prev_q, prev_eff, nxt_sample, sample_q;
  idx_t  idx_q, idx_eff, nxt_idx;
  code_t enc_code, code_use, code_q;
  step_t step;
  logic  mode_q, ready_q, valid_q;
  logic  accept, fresh;

  assign accept   = in_valid_i & ready_q;
  // explicit clear or a change of direction restarts the predictor
  assign fresh    = clear_i | (accept & (mode_i != mode_q));
  assign prev_eff = fresh ? '0 : prev_q;
  assign idx_eff  = fresh ? '0 : idx_q;

  adpcm_step_rom u_rom (
    .idx_i  (idx_eff),
    .step_o (step)
  );

  adpcm_quant u_quant (
    .sample_i (sample_i),
    .prev_i   (prev_eff),
    .step_i   (step),
    .code_o   (enc_code)
  );

  assign code_use = mode_i ? code_i : enc_code;

  adpcm_recon u_recon (
    .code_i   (code_use),
    .prev_i   (prev_eff),
    .step_i   (step),
    .idx_i    (idx_eff),
    .sample_o (nxt_sample),
    .idx_o    (nxt_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      idx_q    <= '0;
      mode_q   <= 1'b0;
      ready_q  <= 1'b0;
      valid_q  <= 1'b0;
      sample_q <= '0;
      code_q   <= '0;
    end else begin
      ready_q <= 1'b1;
      valid_q <= accept;
      if (accept) begin
        prev_q   <= nxt_sample;
        idx_q    <= nxt_idx;
        mode_q   <= mode_i;
        sample_q <= nxt_sample;
        code_q   <= code_use;
      end else if (clear_i) begin
        prev_q <= '0;
        idx_q  <= '0;
      end
    end
  end

  assign in_ready_o  = ready_q;
  assign out_valid_o = valid_q;
  assign sample_o    = sample_q;
  assign code_o      = code_q;

  a_r4_index_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(idx_q) <= IDX_MAX);

  a_r4_index_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (int'(idx_q) + 1 >= int'($past(idx_eff))) &&
                    (int'(idx_q) <= int'($past(idx_eff)) + 8));

  a_r8_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !accept) |=> (prev_q == '0 && idx_q == '0));

  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!accept && !clear_i) |=> ($stable(prev_q) && $stable(idx_q)));
endmodule

// File: tb/adpcm_codec_tb.sv
module adpcm_codec_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clear_i = 1'b0;
  logic        mode_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [15:0] sample_i = '0;
  logic [3:0]  code_i = '0;
  logic        in_ready_o, out_valid_o;
  logic [15:0] sample_o;
  logic [3:0]  code_o;

  always #4 clk = ~clk;

  adpcm_codec u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i), .mode_i(mode_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .sample_i(sample_i),
    .code_i(code_i), .out_valid_o(out_valid_o), .sample_o(sample_o), .code_o(code_o)
  );

  int n_chk = 0, n_bad = 0;
  int st_tab [89];
  int m_prev = 0, m_idx = 0, m_mode = 0;
  bit p_v = 0, p_rt = 0;
  int p_s = 0, p_c = 0, p_rt_s = 0;
  string p_tag = "R1";
  bit rec_on = 0;
  int rec_c[$], rec_s[$];
  bit [31:0] lfsr = 32'h1234_5678;
  bit done = 0;

  task automatic chk(string tag, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic check_out();
    chk("R7", "in_ready", int'(in_ready_o), 1);
    chk(p_tag, "out_valid", int'(out_valid_o), int'(p_v));
    if (p_v) begin
      chk(p_tag, "sample", int'($signed(sample_o)), p_s);
      chk(p_tag, "code", int'(code_o), p_c);
    end
    if (p_rt) chk("R6", "round trip sample", int'($signed(sample_o)), p_rt_s);
  endtask

  // one clock: check last cycle's result, drive new inputs, advance model
  task automatic cyc(bit v, bit m, int s, int c, bit clr, string tag,
                     bit rt = 0, int rts = 0);
    int st, d, code, vp, nv, adj;
    @(negedge clk);
    check_out();
    in_valid_i = v; mode_i = m; sample_i = 16'(s); code_i = 4'(c); clear_i = clr;
    if (clr) begin m_prev = 0; m_idx = 0; end
    if (v) begin
      if (int'(m) != m_mode) begin m_prev = 0; m_idx = 0; end
      m_mode = int'(m);
      st = st_tab[m_idx];
      if (m) code = c;
      else begin
        d = s - m_prev; code = 0;
        if (d < 0) begin code = 8; d = -d; end
        if (d >= st) begin code |= 4; d -= st; end
        if (d >= (st >> 1)) begin code |= 2; d -= (st >> 1); end
        if (d >= (st >> 2)) code |= 1;
      end
      vp = st >> 3;
      if (code & 4) vp += st;
      if (code & 2) vp += st >> 1;
      if (code & 1) vp += st >> 2;
      nv = (code & 8) ? m_prev - vp : m_prev + vp;
      if (nv > 32767) nv = 32767;
      if (nv < -32768) nv = -32768;
      adj = ((code & 7) < 4) ? -1 : 2 * ((code & 7) - 3);
      m_idx += adj;
      if (m_idx < 0) m_idx = 0;
      if (m_idx > 88) m_idx = 88;
      m_prev = nv;
      p_s = nv; p_c = code;
      if (rec_on) begin rec_c.push_back(code); rec_s.push_back(nv); end
    end
    p_v = v; p_tag = tag; p_rt = rt; p_rt_s = rts;
  endtask

  function automatic int rnd(int amp);
    lfsr = lfsr * 32'd1103515245 + 32'd12345;
    return int'($signed(lfsr[30:15])) % amp;
  endfunction

  initial begin
    st_tab[0] = 7;
    for (int i = 1; i < 89; i++) begin
      int n;
      n = (11 * st_tab[i-1] + 5) / 10;
      if (n < st_tab[i-1] + 1) n = st_tab[i-1] + 1;
      if (n > 32767) n = 32767;
      st_tab[i] = n;
    end
    st_tab[88] = 32767;

    repeat (3) @(negedge clk);
    chk("R1", "out_valid in reset", int'(out_valid_o), 0);
    chk("R1", "in_ready in reset", int'(in_ready_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1/R5: first items from the zeroed state, index 0 step 7
    cyc(1, 0, 0, 0, 0, "R1");
    cyc(1, 0, 7, 0, 0, "R5");
    cyc(1, 0, -3, 0, 0, "R2");
    // R2/R10: varied signal with idle gaps
    for (int i = 0; i < 40; i++) begin
      cyc(1, 0, rnd(2000) + i * 50, 0, 0, "R2");
      if (i % 7 == 3) cyc(0, 0, 12345, 9, 0, "R10");
    end
    // R3/R4: full-scale swings saturate and push the index to its top
    for (int i = 0; i < 40; i++) cyc(1, 0, (i % 2) ? -32768 : 32767, 0, 0, "R3");
    for (int i = 0; i < 10; i++) cyc(1, 0, 32767, 0, 0, "R4");
    // R4: long silence walks the index back to its floor
    for (int i = 0; i < 110; i++) cyc(1, 0, 0, 0, 0, "R4");
    // R8: clear alone, then clear concurrent with an item
    cyc(1, 0, 20000, 0, 0, "R8");
    cyc(0, 0, 0, 0, 1, "R8");
    cyc(1, 0, 100, 0, 0, "R8");
    cyc(1, 0, 9000, 0, 0, "R8");
    cyc(1, 0, -500, 0, 1, "R8");
    cyc(1, 0, 300, 0, 0, "R8");
    // R6: compress a message from a cleared state and record it
    cyc(0, 0, 0, 0, 1, "R8");
    rec_on = 1;
    for (int i = 0; i < 60; i++) cyc(1, 0, rnd(30000), 0, 0, "R2");
    rec_on = 0;
    // R9/R6: switching to expand restarts the state; replay the codes
    for (int i = 0; i < 60; i++) cyc(1, 1, 0, rec_c[i], 0, "R6", 1, rec_s[i]);
    // R9: switch back to compress without a clear
    cyc(1, 0, 4000, 0, 0, "R9");
    cyc(1, 0, 4100, 0, 0, "R9");
    // R6: arbitrary codes in expand mode
    cyc(1, 1, 0, 15, 0, "R9");
    for (int i = 0; i < 16; i++) cyc(1, 1, 0, i, 0, "R6");
    cyc(0, 0, 0, 0, 0, "R10");
    cyc(0, 0, 0, 0, 0, "R10");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R7 watchdog: got %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule